// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is an eight-pin general-purpose I/O port on an APB-style register bus. Each pin can be an input or an output, chosen by a direction register. Output pins are driven from an output register, and input pins are sampled through a two-flop synchronizer.

The data register is not at a single address. It is a window of addresses, and bits [9:2] of the access address form a per-pin mask. A read returns only the pins whose mask bits are set. A write changes only the output bits whose mask bits are set. Software can therefore set or clear one pin in a single bus write, with no read-modify-write sequence and no race against other agents that update other pins.

The read value for a pin depends on its direction. An output pin reads back its output register bit, and an input pin reads back its synchronized pin level.

Top module: `gpio_maskwin`

## Requirements
- R1: While reset is asserted, and directly after it, the direction register is 0x00 and the output register is 0x00. Every pin is an input, and pin_o and pin_oe are both 0x00.
- R2: A read inside the data window (offsets 0x000 to 0x3FC, mask = paddr[9:2], mask bit n belongs to pin n) returns 0 in every bit whose mask bit is 0.
- R3: A write inside the data window loads pwdata bit n into output bit n only when mask bit n is 1. Output bits whose mask bit is 0 keep their value.
- R4: The direction register is at offset 0x400. It is 8 bits wide, read and written in full with no masking, and bit n = 1 makes pin n an output. pin_oe bit n always equals direction bit n.
- R5: pin_o bit n always equals output register bit n, whatever the direction.
- R6: In a data read, a selected pin that is an output returns its output register bit, and a selected pin that is an input returns its synchronized input level. A write to a pin that is currently an input still updates that pin's output bit, and the update shows once the pin is made an output.
- R7: A change on pin_i shows in a data read after two rising clock edges and not after one.
- R8: pready is always 1 and pslverr is always 0.
- R9: A read of any other offset (for example 0x404 or 0x800) returns 0x00. A write to such an offset changes neither register.
- R10: A register changes only in the access phase of a write (psel, penable and pwrite all 1). A setup phase with penable at 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits [9:2] are the pin mask inside the data window |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while psel is 1 and pwrite is 0 |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pin_i | input | 8 | Pin levels from the pads, asynchronous |
| pin_o | output | 8 | Output levels to the pads |
| pin_oe | output | 8 | Output enables to the pads, 1 = driven |

## Verification
Two things can happen in the same clock: a masked bus write to the output register and a change on an input pin. The bench provokes this by changing pin_i on the same clock as the access phase of a write. That write's mask covers pins that are currently inputs. The bench then checks three things. The read-back of those pins follows the new pad level after the synchronizer delay. The output bits they were written with appear on pin_o straight away. Those bits are revealed in the read-back once the direction register turns the pins into outputs.

// File: rtl/gpio_maskwin_pkg.sv
package gpio_maskwin_pkg;

   // Which register an access decodes to
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2
   } gmw_sel_e;

   // Bytes per 32-bit register slot on the bus
   localparam int unsigned SLOT_BYTES = 4;
   localparam int unsigned SLOT_SHIFT = 2;

   // Size in bytes of a masked window covering npins mask bits
   function automatic int unsigned window_bytes(input int unsigned npins);
      return SLOT_BYTES << npins;
   endfunction

endpackage

// File: rtl/gpio_mw_decode.sv
module gpio_mw_decode
   import gpio_maskwin_pkg::*;
#(
   parameter int unsigned NPINS   = 8,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DIR_OFF = 'h400
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   output gmw_sel_e          sel,
   output logic [NPINS-1:0]  mask,
   output logic              wr_data,
   output logic              wr_dir,
   output logic              rd_act
);

   localparam int unsigned MASK_LO = SLOT_SHIFT;
   localparam int unsigned MASK_HI = SLOT_SHIFT + NPINS - 1;
   localparam int unsigned TAG_LO  = SLOT_SHIFT + NPINS;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFF);

   logic in_window;
   logic at_dir;
   logic wr_acc;

   // Window: all address bits above the mask field are zero
   assign in_window = (paddr[ADDR_W-1:TAG_LO] == '0);
   // Direction register: exact slot match, byte lanes ignored
   assign at_dir    = (paddr[ADDR_W-1:SLOT_SHIFT] == DIR_ADDR[ADDR_W-1:SLOT_SHIFT]);

   always_comb begin
      if (in_window)   sel = SEL_DATA;
      else if (at_dir) sel = SEL_DIR;
      else             sel = SEL_NONE;
   end

   assign mask    = paddr[MASK_HI:MASK_LO];
   assign wr_acc  = psel & penable & pwrite;
   assign wr_data = wr_acc & (sel == SEL_DATA);
   assign wr_dir  = wr_acc & (sel == SEL_DIR);
   assign rd_act  = psel & ~pwrite;

endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_mw_regs.sv
module gpio_mw_regs #(
   parameter int unsigned NPINS     = 8,
   parameter logic [NPINS-1:0] OUT_RST = '0,
   parameter logic [NPINS-1:0] DIR_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_data,
   input  logic             wr_dir,
   input  logic [NPINS-1:0] mask,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] out_q,
   output logic [NPINS-1:0] dir_q
);

   // Output register: one enable per bit, taken from the address mask
   for (genvar b = 0; b < NPINS; b++) begin : g_outbit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   out_q[b] <= OUT_RST[b];
         else if (wr_data && mask[b])  out_q[b] <= wdata[b];
      end
   end

   // Direction register: full-width write, no masking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= DIR_RST;
      else if (wr_dir) dir_q <= wdata;
   end

endmodule

// File: rtl/gpio_mw_rdmux.sv
module gpio_mw_rdmux
   import gpio_maskwin_pkg::*;
#(
   parameter int unsigned NPINS = 8
) (
   input  logic             rd_act,
   input  gmw_sel_e         sel,
   input  logic [NPINS-1:0] mask,
   input  logic [NPINS-1:0] out_q,
   input  logic [NPINS-1:0] dir_q,
   input  logic [NPINS-1:0] pin_sync,
   output logic [NPINS-1:0] rdata
);

   logic [NPINS-1:0] level;

   // Per-pin source: driven value for outputs, pad level for inputs
   for (genvar b = 0; b < NPINS; b++) begin : g_src
      assign level[b] = dir_q[b] ? out_q[b] : pin_sync[b];
   end

   always_comb begin
      rdata = '0;
      if (rd_act) begin
         unique case (sel)
            SEL_DATA: rdata = level & mask;
            SEL_DIR:  rdata = dir_q;
            default:  rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_maskwin.sv
module gpio_maskwin
   import gpio_maskwin_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DIR_OFF     = 'h400,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [NPINS-1:0]  pwdata,
   output logic [NPINS-1:0]  prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [NPINS-1:0]  pin_i,
   output logic [NPINS-1:0]  pin_o,
   output logic [NPINS-1:0]  pin_oe
);

   localparam int unsigned WIN_BYTES = window_bytes(NPINS);

   // Elaboration-time parameter checks
   if (NPINS < 1 || NPINS > 16) begin : g_bad_npins
      $error("gpio_maskwin: NPINS out of range");
   end
   if (ADDR_W <= NPINS + SLOT_SHIFT) begin : g_bad_addr_w
      $error("gpio_maskwin: ADDR_W too narrow for mask window");
   end
   if (DIR_OFF < WIN_BYTES || (DIR_OFF % SLOT_BYTES) != 0) begin : g_bad_dir_off
      $error("gpio_maskwin: DIR_OFF overlaps window or is misaligned");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_maskwin: at least two synchronizer stages required");
   end

   gmw_sel_e         sel;
   logic [NPINS-1:0] mask;
   logic             wr_data;
   logic             wr_dir;
   logic             rd_act;
   logic [NPINS-1:0] out_q;
   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] pin_sync;

   gpio_mw_decode #(
      .NPINS   (NPINS),
      .ADDR_W  (ADDR_W),
      .DIR_OFF (DIR_OFF)
   ) u_decode (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .sel     (sel),
      .mask    (mask),
      .wr_data (wr_data),
      .wr_dir  (wr_dir),
      .rd_act  (rd_act)
   );

   gpio_mw_sync #(
      .WIDTH  (NPINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (pclk),
      .rst_n   (presetn),
      .d_async (pin_i),
      .q_sync  (pin_sync)
   );

   gpio_mw_regs #(
      .NPINS   (NPINS),
      .OUT_RST ('0),
      .DIR_RST ('0)
   ) u_regs (
      .clk     (pclk),
      .rst_n   (presetn),
      .wr_data (wr_data),
      .wr_dir  (wr_dir),
      .mask    (mask),
      .wdata   (pwdata),
      .out_q   (out_q),
      .dir_q   (dir_q)
   );

   gpio_mw_rdmux #(
      .NPINS (NPINS)
   ) u_rdmux (
      .rd_act   (rd_act),
      .sel      (sel),
      .mask     (mask),
      .out_q    (out_q),
      .dir_q    (dir_q),
      .pin_sync (pin_sync),
      .rdata    (prdata)
   );

   assign pin_o   = out_q;
   assign pin_oe  = dir_q;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

endmodule

// File: rtl/gpio_maskwin_chk.sv
module gpio_maskwin_chk #(
   parameter int unsigned NPINS   = 8,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DIR_OFF = 'h400
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [NPINS-1:0]  pwdata,
   input logic [NPINS-1:0]  prdata,
   input logic              pready,
   input logic              pslverr,
   input logic [NPINS-1:0]  pin_o,
   input logic [NPINS-1:0]  pin_oe
);

   logic             c_win;
   logic             c_dir;
   logic             c_wr;
   logic [NPINS-1:0] c_mask;

   assign c_win  = ((paddr >> (NPINS + 2)) == '0);
   assign c_dir  = ((paddr >> 2) == ADDR_W'(DIR_OFF >> 2));
   assign c_wr   = psel & penable & pwrite;
   assign c_mask = paddr[NPINS+1:2];

   // R1
   always @(negedge pclk) begin
      if (!presetn) begin
         reset_clear_chk: assert (pin_o == '0 && pin_oe == '0);
      end
   end

   // R3
   masked_bits_load_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (c_wr && c_win) |=> ((pin_o & $past(c_mask)) == ($past(pwdata) & $past(c_mask))));

   // R3
   unmasked_bits_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (c_wr && c_win) |=> ((pin_o & ~$past(c_mask)) == ($past(pin_o) & ~$past(c_mask))));

   // R4
   dir_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      !(c_wr && c_dir) |=> $stable(pin_oe));

   // R4
   dir_load_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (c_wr && c_dir) |=> (pin_oe == $past(pwdata)));

   // R10
   out_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      !(c_wr && c_win) |=> $stable(pin_o));

   // R2
   read_mask_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && c_win) |-> ((prdata & ~c_mask) == '0));

   // R9
   unmapped_read_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && !c_win && !c_dir) |-> (prdata == '0));

   // R8
   resp_const_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (pready == 1'b1 && pslverr == 1'b0));

endmodule

bind gpio_maskwin gpio_maskwin_chk #(
   .NPINS   (NPINS),
   .ADDR_W  (ADDR_W),
   .DIR_OFF (DIR_OFF)
) u_chk (
   .pclk    (pclk),
   .presetn (presetn),
   .psel    (psel),
   .penable (penable),
   .pwrite  (pwrite),
   .paddr   (paddr),
   .pwdata  (pwdata),
   .prdata  (prdata),
   .pready  (pready),
   .pslverr (pslverr),
   .pin_o   (pin_o),
   .pin_oe  (pin_oe)
);

// File: tb/sim_gpio_maskwin.sv
module sim_gpio_maskwin;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [7:0]  pwdata = '0;
   logic [7:0]  prdata;
   logic        pready;
   logic        pslverr;
   logic [7:0]  pin_i = 8'hA5;
   logic [7:0]  pin_o;
   logic [7:0]  pin_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 pclk = ~pclk;

   gpio_maskwin u0 (
      .pclk    (pclk),
      .presetn (presetn),
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .pwdata  (pwdata),
      .prdata  (prdata),
      .pready  (pready),
      .pslverr (pslverr),
      .pin_i   (pin_i),
      .pin_o   (pin_o),
      .pin_oe  (pin_oe)
   );

   // vector: {is_write, addr[11:0], wdata[7:0], expected read[7:0]}
   localparam int NV = 20;
   localparam logic [28:0] VEC [NV] = '{
      {1'b0, 12'h400, 8'h00, 8'h00},  // dir after reset
      {1'b0, 12'h3FC, 8'h00, 8'hA5},  // all inputs, full mask
      {1'b0, 12'h03C, 8'h00, 8'h05},  // low nibble mask
      {1'b1, 12'h400, 8'hF0, 8'h00},  // upper nibble outputs
      {1'b0, 12'h400, 8'h00, 8'hF0},
      {1'b1, 12'h3FC, 8'h3C, 8'h00},  // out = 3C
      {1'b0, 12'h3FC, 8'h00, 8'h35},
      {1'b1, 12'h100, 8'h40, 8'h00},  // set pin 6 only
      {1'b0, 12'h3FC, 8'h00, 8'h75},
      {1'b1, 12'h080, 8'h00, 8'h00},  // clear pin 5 only
      {1'b0, 12'h3FC, 8'h00, 8'h55},
      {1'b1, 12'h0C0, 8'hFF, 8'h00},  // set pins 4,5
      {1'b0, 12'h0C0, 8'h00, 8'h30},
      {1'b1, 12'h404, 8'hFF, 8'h00},  // unmapped write
      {1'b0, 12'h404, 8'h00, 8'h00},
      {1'b0, 12'h400, 8'h00, 8'hF0},
      {1'b1, 12'h800, 8'hFF, 8'h00},  // unmapped write
      {1'b0, 12'h800, 8'h00, 8'h00},
      {1'b0, 12'h400, 8'h00, 8'hF0},
      {1'b0, 12'h3FC, 8'h00, 8'h75}
   };
   string vreq [NV] = '{
      "R1", "R6", "R2", "R4", "R4", "R3", "R6", "R3", "R3", "R3",
      "R3", "R3", "R2", "R9", "R9", "R9", "R9", "R9", "R9", "R3"
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [7:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      d = prdata;
      // R8 response signals during the access phase
      chk("R8", {6'd0, pready, pslverr}, 8'h02);
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      // R1 reset state
      repeat (3) @(negedge pclk);
      chk("R1", pin_o, 8'h00);
      chk("R1", pin_oe, 8'h00);
      chk("R8", {6'd0, pready, pslverr}, 8'h02);
      presetn = 1'b1;
      repeat (3) @(negedge pclk);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][28]) begin
            apb_wr(VEC[i][27:16], VEC[i][15:8]);
         end else begin
            apb_rd(VEC[i][27:16], rd);
            chk(vreq[i], rd, VEC[i][7:0]);
         end
      end

      // R5 / R4 pad outputs after table
      chk("R5", pin_o, 8'h7C);
      chk("R4", pin_oe, 8'hF0);

      // R10 setup phase only: no change
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h3FC; pwdata = 8'h00;
      repeat (2) @(negedge pclk);
      psel = 1'b0; pwrite = 1'b0;
      paddr = 12'h400;
      @(negedge pclk);
      chk("R10", pin_o, 8'h7C);
      chk("R10", pin_oe, 8'hF0);

      // R7 synchronizer latency
      @(negedge pclk);
      pin_i = 8'h5A; psel = 1'b1; pwrite = 1'b0; paddr = 12'h03C;
      @(negedge pclk);
      #1;
      chk("R7", prdata, 8'h05);
      @(negedge pclk);
      #1;
      chk("R7", prdata, 8'h0A);
      psel = 1'b0;

      // R6 write to input pins while their pad level changes
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h03C; pwdata = 8'h0F;
      @(negedge pclk);
      penable = 1'b1; pin_i = 8'h00;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      chk("R5", pin_o, 8'h7F);
      repeat (2) @(negedge pclk);
      apb_rd(12'h03C, rd);
      chk("R6", rd, 8'h00);
      apb_wr(12'h400, 8'hFF);
      apb_rd(12'h3FC, rd);
      chk("R6", rd, 8'h7F);
      chk("R4", pin_oe, 8'hFF);

      finish_run();
   end

endmodule